// File: doc/BRIEF.md
# Fairness-Driven Cache Repartition Controller

This controller decides how much shared-cache capacity each of two threads may hold. It counts each thread's accesses and misses over an interval whose length is a number of accesses. At the end of the interval it compares the two threads' slowdown estimates. A thread's slowdown estimate is its miss rate while sharing, divided by its miss rate when running alone, and the alone rate is supplied from outside. The controller then moves one granule of capacity from the thread that suffers less to the thread that suffers more. A replacement selector reads the two targets, which are in granules, and enforces them.

Before each forward move, the controller checks whether the previous move helped. It compares the miss rate of the thread that last gained capacity in the interval before the gain against the interval after it. If the improvement is smaller than a programmed threshold, the controller takes the granule back instead of making a new move. All comparisons use cross-multiplication, so the block has no divider. A decision takes a fixed two cycles after the interval closes, and a one-cycle strobe marks the moment the new targets are valid.

Top module: `fair_repart_ctrl`

## Requirements
- R1: While reset is low, and in the first cycle after it, each target is TOTAL_GR/2 granules (4 of 8 by default) and the update strobe is low.
- R2: An access is counted on a thread only when its access input is high, and a miss only when both its access and miss inputs are high. An interval closes at the clock edge where the interval's total access count over both threads first reaches a nonzero interval length. That edge also captures the counts and clears the counters. No decision is made before the interval closes, and idle cycles or stray miss pulses without an access do not change the outcome.
- R3: The update strobe is high for exactly one cycle. It and any target change appear after the second clock edge following the closing edge. Targets never change while the strobe is low.
- R4: Let n be misses, a accesses and r the alone rate. Thread A is more slowed when nA·aB·rB > nB·aA·rA and the two products are not tied. In that case one granule moves from B to A, and the opposite case mirrors this.
- R5: The products are tied when their absolute difference is at most the larger product shifted right by TIE_SH (3 by default). A tie makes no move.
- R6: Each target stays at least 1 granule, the two targets always sum to TOTAL_GR, and a forward move that would break the floor is skipped.
- R7: Suppose the previous decision moved a granule forward to thread g. Let (om, oa) be g's counts from the interval that caused the move and (nm, na) be its counts from the interval just closed. If (om·na − nm·oa)·2^RATE_W < thr·oa·na, taken as signed, the granule returns to the other thread and no forward move is made. A rollback is never itself rolled back.
- R8: A thread with zero accesses, or with a zero alone rate, has a slowdown estimate of zero. A zero-access interval counts as a miss rate of zero in the rollback test.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| acc_a | input | 1 | Thread A cache access this cycle |
| miss_a | input | 1 | Thread A access missed |
| acc_b | input | 1 | Thread B cache access this cycle |
| miss_b | input | 1 | Thread B access missed |
| ivl_len | input | CNT_W | Interval length in accesses over both threads |
| alone_rate_a | input | RATE_W | Thread A alone miss rate, fraction scaled by 2^RATE_W |
| alone_rate_b | input | RATE_W | Thread B alone miss rate, same scale |
| rb_thresh | input | RATE_W | Minimum miss-rate improvement, same scale |
| tgt_a | output | $clog2(TOTAL_GR+1) | Thread A target in granules |
| tgt_b | output | $clog2(TOTAL_GR+1) | Thread B target in granules |
| upd_strobe | output | 1 | New targets valid this cycle |

## Verification
The closing edge is the one that samples the access that completes the interval. The counts are captured there, the products and the rollback test are registered one edge later, and the targets and strobe update at the second edge after the closing edge. The bench drives inputs on falling edges. It checks that the strobe is low and the old targets hold half a cycle after the closing edge and after the next edge, that the new targets and the strobe appear half a cycle after the second edge, and that the strobe is low again one cycle later. During each interval, including inserted idle gaps, the bench also confirms that the strobe stays low.

// File: rtl/rpc_pkg.sv
// Shared types for the repartition controller: decision sequencer states
// and the record of which way the last granule moved.
package rpc_pkg;
    typedef enum logic [1:0] {ST_IDLE, ST_CALC, ST_DEC} dec_state_e;
    typedef enum logic [1:0] {MV_NONE, MV_TO_A, MV_TO_B} move_e;
endpackage

// File: rtl/rpc_event_counter.sv
// Per-thread access and miss counter for one interval.
// Assumes a miss pulse only means something together with an access pulse.
// Presents the count including this cycle's event so a closing edge can
// capture it; both counts saturate at their maximum.
module rpc_event_counter #(
    parameter int CNT_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             acc_i,
    input  logic             miss_i,
    input  logic             clr_i,
    output logic [CNT_W-1:0] acc_nx_o,
    output logic [CNT_W-1:0] miss_nx_o
);
    localparam logic [CNT_W-1:0] CMAX = '1;

    logic [CNT_W-1:0] acc_q, miss_q;

    // next counts with saturation
    always_comb begin
        acc_nx_o  = (acc_i && acc_q != CMAX) ? acc_q + 1'b1 : acc_q;
        miss_nx_o = (acc_i && miss_i && miss_q != CMAX) ? miss_q + 1'b1 : miss_q;
    end

    // count register, cleared at an interval close
    always_ff @(posedge clk) begin
        if (!rst_n || clr_i) begin
            acc_q  <= '0;
            miss_q <= '0;
        end else begin
            acc_q  <= acc_nx_o;
            miss_q <= miss_nx_o;
        end
    end
endmodule

// File: rtl/rpc_fair_cmp.sv
// Slowdown comparator: decides which thread is more slowed using
// cross-multiplied miss-rate ratios, with a relative tie band.
// Assumes inputs are stable for the cycle before its registered result is used.
module rpc_fair_cmp #(
    parameter int CNT_W  = 12,
    parameter int RATE_W = 8,
    parameter int TIE_SH = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CNT_W-1:0]  acc_a_i,
    input  logic [CNT_W-1:0]  miss_a_i,
    input  logic [RATE_W-1:0] rate_a_i,
    input  logic [CNT_W-1:0]  acc_b_i,
    input  logic [CNT_W-1:0]  miss_b_i,
    input  logic [RATE_W-1:0] rate_b_i,
    output logic              a_slow_o,
    output logic              b_slow_o
);
    localparam int DW = CNT_W + RATE_W;
    localparam int PW = CNT_W + DW;

    logic          zero_a, zero_b, band;
    logic [DW-1:0] den_a, den_b;
    logic [PW-1:0] num_a, num_b, lhs, rhs, gap, big;

    // ratio products, a zero denominator means a slowdown of zero
    always_comb begin
        zero_a = (acc_a_i == '0) || (rate_a_i == '0);
        zero_b = (acc_b_i == '0) || (rate_b_i == '0);
        num_a  = zero_a ? '0 : PW'(miss_a_i);
        num_b  = zero_b ? '0 : PW'(miss_b_i);
        den_a  = zero_a ? DW'(1) : DW'(acc_a_i) * DW'(rate_a_i);
        den_b  = zero_b ? DW'(1) : DW'(acc_b_i) * DW'(rate_b_i);
        lhs    = num_a * PW'(den_b);
        rhs    = num_b * PW'(den_a);
        gap    = (lhs > rhs) ? lhs - rhs : rhs - lhs;
        big    = (lhs > rhs) ? lhs : rhs;
        band   = gap <= (big >> TIE_SH);
    end

    // registered verdict
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            a_slow_o <= 1'b0;
            b_slow_o <= 1'b0;
        end else begin
            a_slow_o <= !band && (lhs > rhs);
            b_slow_o <= !band && (rhs > lhs);
        end
    end
endmodule

// File: rtl/rpc_gain_check.sv
// Rollback test: flags when the gaining thread's miss rate fell by less than
// the threshold between two intervals. Rates are compared by cross-products;
// a zero-access interval counts as rate zero.
module rpc_gain_check #(
    parameter int CNT_W  = 12,
    parameter int RATE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CNT_W-1:0]  old_m_i,
    input  logic [CNT_W-1:0]  old_a_i,
    input  logic [CNT_W-1:0]  new_m_i,
    input  logic [CNT_W-1:0]  new_a_i,
    input  logic [RATE_W-1:0] thr_i,
    output logic              short_o
);
    localparam int QW = 2 * CNT_W;
    localparam int TW = RATE_W + QW;
    localparam int LW = TW + 2;

    logic [CNT_W-1:0]     om, oa, nm, na;
    logic [QW-1:0]        p_on, p_no;
    logic [TW-1:0]        p_thr;
    logic signed [LW-1:0] diff_s, scaled_s, rhs_s;

    // improvement compared against threshold, all in signed fixed point
    always_comb begin
        om       = (old_a_i == '0) ? '0 : old_m_i;
        oa       = (old_a_i == '0) ? CNT_W'(1) : old_a_i;
        nm       = (new_a_i == '0) ? '0 : new_m_i;
        na       = (new_a_i == '0) ? CNT_W'(1) : new_a_i;
        p_on     = QW'(om) * QW'(na);
        p_no     = QW'(nm) * QW'(oa);
        p_thr    = TW'(thr_i) * TW'(oa) * TW'(na);
        diff_s   = $signed(LW'(p_on)) - $signed(LW'(p_no));
        scaled_s = diff_s <<< RATE_W;
        rhs_s    = $signed(LW'(p_thr));
    end

    // registered verdict
    always_ff @(posedge clk) begin
        if (!rst_n) short_o <= 1'b0;
        else        short_o <= scaled_s < rhs_s;
    end
endmodule

// File: rtl/fair_repart_ctrl.sv
// Two-thread fairness repartition controller. Counts accesses per interval,
// closes the interval when the total reaches ivl_len, then two cycles later
// moves one granule toward the more slowed thread or rolls back a move
// that did not help. Assumes rates and threshold are steady during a decision.
// A close that would fall while a decision is in flight waits until it ends.
module fair_repart_ctrl #(
    parameter int CNT_W    = 12,
    parameter int RATE_W   = 8,
    parameter int TOTAL_GR = 8,
    parameter int TIE_SH   = 3,
    localparam int GW      = $clog2(TOTAL_GR + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_a,
    input  logic              miss_a,
    input  logic              acc_b,
    input  logic              miss_b,
    input  logic [CNT_W-1:0]  ivl_len,
    input  logic [RATE_W-1:0] alone_rate_a,
    input  logic [RATE_W-1:0] alone_rate_b,
    input  logic [RATE_W-1:0] rb_thresh,
    output logic [GW-1:0]     tgt_a,
    output logic [GW-1:0]     tgt_b,
    output logic              upd_strobe
);
    import rpc_pkg::*;

    localparam int NTHR = 2;
    localparam int TW   = CNT_W + 2;
    localparam logic [GW-1:0] HALF = GW'(TOTAL_GR / 2);
    localparam logic [GW-1:0] FULL = GW'(TOTAL_GR);
    localparam logic [CNT_W:0] TMAX = '1;

    logic [NTHR-1:0]  acc_v, miss_v;
    logic [CNT_W-1:0] acc_nx [NTHR];
    logic [CNT_W-1:0] miss_nx[NTHR];
    logic [CNT_W-1:0] snap_a [NTHR];
    logic [CNT_W-1:0] snap_m [NTHR];
    logic [CNT_W-1:0] prev_a [NTHR];
    logic [CNT_W-1:0] prev_m [NTHR];
    logic [CNT_W:0]   tot_q;
    logic [TW-1:0]    tot_sum;
    logic             bnd, a_slow, b_slow, shortfall, g_sel;
    dec_state_e       st_q;
    move_e            last_q;
    logic [GW-1:0]    ta_q, tb_q;
    logic             upd_q;

    assign acc_v  = {acc_b, acc_a};
    assign miss_v = {miss_b, miss_a};

    generate
        for (genvar t = 0; t < NTHR; t++) begin : g_thr
            rpc_event_counter #(.CNT_W(CNT_W)) u_cnt (
                .clk(clk), .rst_n(rst_n), .acc_i(acc_v[t]), .miss_i(miss_v[t]),
                .clr_i(bnd), .acc_nx_o(acc_nx[t]), .miss_nx_o(miss_nx[t])
            );
        end
    endgenerate

    // interval close detection on the running total
    always_comb begin
        tot_sum = TW'(tot_q) + TW'(acc_v[0]) + TW'(acc_v[1]);
        bnd     = (st_q == ST_IDLE) && (ivl_len != '0) && (tot_sum >= TW'(ivl_len));
    end

    // running total of the interval, saturating
    always_ff @(posedge clk) begin
        if (!rst_n || bnd)          tot_q <= '0;
        else if (tot_sum > TW'(TMAX)) tot_q <= TMAX;
        else                        tot_q <= tot_sum[CNT_W:0];
    end

    // capture of the closed interval's counts
    always_ff @(posedge clk) begin
        for (int t = 0; t < NTHR; t++) begin
            if (!rst_n) begin
                snap_a[t] <= '0;
                snap_m[t] <= '0;
            end else if (bnd) begin
                snap_a[t] <= acc_nx[t];
                snap_m[t] <= miss_nx[t];
            end
        end
    end

    // decision sequencer
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= ST_IDLE;
        else case (st_q)
            ST_IDLE: if (bnd) st_q <= ST_CALC;
            ST_CALC: st_q <= ST_DEC;
            default: st_q <= ST_IDLE;
        endcase
    end

    rpc_fair_cmp #(.CNT_W(CNT_W), .RATE_W(RATE_W), .TIE_SH(TIE_SH)) u_cmp (
        .clk(clk), .rst_n(rst_n),
        .acc_a_i(snap_a[0]), .miss_a_i(snap_m[0]), .rate_a_i(alone_rate_a),
        .acc_b_i(snap_a[1]), .miss_b_i(snap_m[1]), .rate_b_i(alone_rate_b),
        .a_slow_o(a_slow), .b_slow_o(b_slow)
    );

    assign g_sel = (last_q == MV_TO_B);

    rpc_gain_check #(.CNT_W(CNT_W), .RATE_W(RATE_W)) u_gain (
        .clk(clk), .rst_n(rst_n),
        .old_m_i(prev_m[g_sel]), .old_a_i(prev_a[g_sel]),
        .new_m_i(snap_m[g_sel]), .new_a_i(snap_a[g_sel]),
        .thr_i(rb_thresh), .short_o(shortfall)
    );

    // target update: rollback first, else a forward move within the floor
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ta_q   <= HALF;
            tb_q   <= FULL - HALF;
            last_q <= MV_NONE;
            upd_q  <= 1'b0;
            for (int t = 0; t < NTHR; t++) begin
                prev_a[t] <= '0;
                prev_m[t] <= '0;
            end
        end else if (st_q == ST_DEC) begin
            upd_q <= 1'b1;
            for (int t = 0; t < NTHR; t++) begin
                prev_a[t] <= snap_a[t];
                prev_m[t] <= snap_m[t];
            end
            if (last_q != MV_NONE && shortfall) begin
                if (last_q == MV_TO_A) begin
                    ta_q <= ta_q - 1'b1;
                    tb_q <= tb_q + 1'b1;
                end else begin
                    ta_q <= ta_q + 1'b1;
                    tb_q <= tb_q - 1'b1;
                end
                last_q <= MV_NONE;
            end else if (a_slow && tb_q > GW'(1)) begin
                ta_q   <= ta_q + 1'b1;
                tb_q   <= tb_q - 1'b1;
                last_q <= MV_TO_A;
            end else if (b_slow && ta_q > GW'(1)) begin
                ta_q   <= ta_q - 1'b1;
                tb_q   <= tb_q + 1'b1;
                last_q <= MV_TO_B;
            end else begin
                last_q <= MV_NONE;
            end
        end else begin
            upd_q <= 1'b0;
        end
    end

    assign tgt_a      = ta_q;
    assign tgt_b      = tb_q;
    assign upd_strobe = upd_q;
endmodule

// File: rtl/rpc_checker.sv
// Port-level property checker for the repartition controller, bound to the top.
module rpc_checker #(
    parameter int TOTAL_GR = 8,
    parameter int GW       = 4
) (
    input logic          clk,
    input logic          rst_n,
    input logic [GW-1:0] tgt_a,
    input logic [GW-1:0] tgt_b,
    input logic          upd_strobe
);
    localparam logic [GW:0]   FULL = (GW+1)'(TOTAL_GR);
    localparam logic [GW-1:0] HALF = GW'(TOTAL_GR / 2);

    AST_RESET_SPLIT: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (tgt_a == HALF) && !upd_strobe); // R1
    AST_SUM_CONST: assert property (@(posedge clk) disable iff (!rst_n)
        ({1'b0, tgt_a} + {1'b0, tgt_b}) == FULL); // R6
    AST_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
        (tgt_a != '0) && (tgt_b != '0)); // R6
    AST_HOLD_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !upd_strobe |-> $stable(tgt_a) && $stable(tgt_b)); // R3
    AST_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        upd_strobe |=> !upd_strobe); // R3
    AST_ONE_GRANULE: assert property (@(posedge clk) disable iff (!rst_n)
        upd_strobe |-> (tgt_a == $past(tgt_a)) || (tgt_a == $past(tgt_a) + 1'b1)
                       || (tgt_a + 1'b1 == $past(tgt_a))); // R4
endmodule

bind fair_repart_ctrl rpc_checker #(.TOTAL_GR(TOTAL_GR), .GW(GW)) u_chk (
    .clk(clk), .rst_n(rst_n), .tgt_a(tgt_a), .tgt_b(tgt_b), .upd_strobe(upd_strobe)
);

// File: tb/fair_repart_ctrl_tb_top.sv
module fair_repart_ctrl_tb_top;
    localparam int CNT_W = 12, RATE_W = 8, TOTAL_GR = 8, TIE_SH = 3, GW = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic acc_a = 0, miss_a = 0, acc_b = 0, miss_b = 0;
    logic [CNT_W-1:0]  ivl_len = '0;
    logic [RATE_W-1:0] alone_rate_a = 8'd32, alone_rate_b = 8'd32, rb_thresh = '0;
    logic [GW-1:0] tgt_a, tgt_b;
    logic upd_strobe;

    int nchk = 0, nfail = 0;
    bit done = 0;

    longint m_ta = 4, m_tb = 4;
    int     m_last = 0;              // 0 none, 1 to A, 2 to B
    longint pa[2] = '{0, 0};
    longint pm[2] = '{0, 0};

    always #5 clk = ~clk;

    fair_repart_ctrl #(.CNT_W(CNT_W), .RATE_W(RATE_W), .TOTAL_GR(TOTAL_GR), .TIE_SH(TIE_SH)) dut_i (
        .clk(clk), .rst_n(rst_n), .acc_a(acc_a), .miss_a(miss_a), .acc_b(acc_b), .miss_b(miss_b),
        .ivl_len(ivl_len), .alone_rate_a(alone_rate_a), .alone_rate_b(alone_rate_b),
        .rb_thresh(rb_thresh), .tgt_a(tgt_a), .tgt_b(tgt_b), .upd_strobe(upd_strobe)
    );

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // expected decision from the requirement arithmetic; returns the tag checked
    function automatic string model(longint na, longint ma, longint nb, longint mb);
        longint ra = alone_rate_a, rb = alone_rate_b, thr = rb_thresh;
        longint numa, numb, dena, denb, l, r, gap, big, om, oa, nm, nn;
        longint ca[2], cm[2];
        bit tie, sf;
        string tag;
        ca[0] = na; cm[0] = ma; ca[1] = nb; cm[1] = mb;
        numa = (na == 0 || ra == 0) ? 0 : ma;  dena = (na == 0 || ra == 0) ? 1 : na * ra;
        numb = (nb == 0 || rb == 0) ? 0 : mb;  denb = (nb == 0 || rb == 0) ? 1 : nb * rb;
        l = numa * denb; r = numb * dena;
        gap = (l > r) ? l - r : r - l; big = (l > r) ? l : r;
        tie = gap <= (big >>> TIE_SH);
        sf = 0;
        if (m_last != 0) begin
            int g = m_last - 1;
            om = (pa[g] == 0) ? 0 : pm[g]; oa = (pa[g] == 0) ? 1 : pa[g];
            nm = (ca[g] == 0) ? 0 : cm[g]; nn = (ca[g] == 0) ? 1 : ca[g];
            sf = ((om * nn - nm * oa) * 256) < thr * oa * nn;
        end
        if (m_last != 0 && sf) begin
            if (m_last == 1) begin m_ta--; m_tb++; end else begin m_ta++; m_tb--; end
            m_last = 0; tag = "R7";
        end else if (!tie && l > r && m_tb > 1) begin
            m_ta++; m_tb--; m_last = 1; tag = "R4";
        end else if (!tie && r > l && m_ta > 1) begin
            m_ta--; m_tb++; m_last = 2; tag = "R4";
        end else begin
            m_last = 0;
            tag = tie ? "R5" : "R6";
        end
        if (na == 0 || nb == 0 || ra == 0 || rb == 0) tag = {tag, "/R8"};
        pa = ca; pm = cm;
        return tag;
    endfunction

    // drives one interval of na/nb accesses with ma/mb misses, then checks the decision
    task automatic run_interval(input int na, input int ma, input int nb, input int mb,
                                input int gap, input bit junk);
        int n = (na > nb) ? na : nb;
        longint old_a = m_ta, old_b = m_tb;
        string tag;
        ivl_len = CNT_W'(na + nb);
        for (int k = 0; k < n; k++) begin
            if (k == n / 2) begin
                for (int g = 0; g < gap; g++) begin
                    @(negedge clk);
                    acc_a = 0; acc_b = 0; miss_a = junk; miss_b = junk;
                    chk(upd_strobe == 0, "R2 quiet in gap", upd_strobe, 0);
                end
            end
            @(negedge clk);
            if (k > 0) chk(upd_strobe == 0, "R2 quiet inside interval", upd_strobe, 0);
            acc_a  = (k < na);
            miss_a = (k < ma) || (junk && k >= na);
            acc_b  = (k < nb);
            miss_b = (k < mb) || (junk && k >= nb);
        end
        tag = model(na, ma, nb, mb);
        @(negedge clk);                 // after closing edge
        acc_a = 0; acc_b = 0; miss_a = 0; miss_b = 0;
        chk(upd_strobe == 0, "R3 strobe low at close+0", upd_strobe, 0);
        chk(tgt_a == old_a, "R3 target held at close+0", tgt_a, old_a);
        @(negedge clk);
        chk(upd_strobe == 0, "R3 strobe low at close+1", upd_strobe, 0);
        chk(tgt_a == old_a, "R3 target held at close+1", tgt_a, old_a);
        @(negedge clk);
        chk(upd_strobe == 1, "R3 strobe high at close+2", upd_strobe, 1);
        chk(tgt_a == m_ta, {tag, " tgt_a"}, tgt_a, m_ta);
        chk(tgt_b == m_tb, {tag, " tgt_b"}, tgt_b, m_tb);
        chk(tgt_a + tgt_b == TOTAL_GR && tgt_a >= 1 && tgt_b >= 1, "R6 sum and floor",
            tgt_a + tgt_b, TOTAL_GR);
        @(negedge clk);
        chk(upd_strobe == 0, "R3 strobe single cycle", upd_strobe, 0);
    endtask

    // watchdog
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            nfail++; nchk++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(tgt_a == 4, "R1 reset tgt_a", tgt_a, 4);
        chk(tgt_b == 4, "R1 reset tgt_b", tgt_b, 4);
        chk(upd_strobe == 0, "R1 reset strobe", upd_strobe, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(tgt_a == 4 && upd_strobe == 0, "R1 first cycle after reset", tgt_a, 4);

        // sweep of miss mixes with two alone-rate settings, no threshold
        rb_thresh = 0;
        for (int ri = 0; ri < 2; ri++) begin
            alone_rate_a = (ri == 0) ? 8'd16 : 8'd64;
            alone_rate_b = 8'd32;
            for (int ma = 0; ma <= 4; ma++)
                for (int mb = 0; mb <= 4; mb++)
                    run_interval(4, ma, 4, mb, (ma == mb) ? 2 : 0, ma[0]);
        end

        // unequal and zero access counts, zero alone rate, with a threshold
        rb_thresh = 8'd40;
        alone_rate_a = 8'd32; alone_rate_b = 8'd48;
        for (int na = 0; na <= 6; na += 3)
            for (int nb = 0; nb <= 6; nb += 3)
                for (int s = 0; s < 3; s++) begin
                    if (na + nb == 0) continue;
                    run_interval(na, (na * s) / 2, nb, (nb * (2 - s)) / 2, 1, s[0]);
                end
        alone_rate_b = 8'd0;
        run_interval(5, 5, 5, 0, 0, 0);
        run_interval(5, 1, 5, 5, 0, 1);
        alone_rate_b = 8'd32;

        // floor: keep thread A maximally slowed with no rollback
        rb_thresh = 0;
        for (int i = 0; i < 9; i++) run_interval(6, 6, 6, 0, 0, 0);
        chk(tgt_b == 1, "R6 floor reached", tgt_b, 1);

        // large threshold: every forward move is followed by a rollback
        rb_thresh = 8'd128;
        for (int i = 0; i < 6; i++) run_interval(6, 0, 6, 6, 0, 0);
        for (int i = 0; i < 4; i++) run_interval(8, 2 * i, 4, 4 - i, 1, 1);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end
endmodule